// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block is a clocked model of the write-control logic of a byte-wide nonvolatile memory. It has active-low chip, output and write enables, a 15-bit address and an 8-bit data path, and it samples all of them on the system clock. A write strobe is recognised only while chip enable and write enable are both low and output enable is high. Strobes shorter than a minimum number of cycles are discarded as noise. Accepted byte loads collect in a page buffer of up to 64 bytes. Every load must carry the page number of the first load in the page.

After the last load, the controller waits a fixed window of idle cycles. It then enters a self-timed programming phase of fixed length and copies every loaded byte into the backing array. During that phase a read returns polling status instead of array data. The top bit of the status is the inverse of the top bit of the last byte loaded. The next bit flips after every completed read. Writes issued during that phase are ignored.

The backing array holds 2^MEM_AW bytes. Address bits above that width alias.

Top module: `nvm_page_writer`

## Requirements
- R1: A write strobe exists only while ce_n=0, we_n=0 and oe_n=1. The address is taken when the strobe begins, which is the later of the two enable falls. The data is the din value in the strobe's final cycle, which is the earlier of the two enable rises. Holding oe_n low throughout blocks the write.
- R2: A strobe lasting fewer than MIN_PULSE clock cycles loads nothing. A strobe of MIN_PULSE cycles or longer loads one byte.
- R3: Loads gather into one page while each new strobe starts within LOAD_WINDOW idle cycles of the previous one ending. Programming (busy=1) begins between LOAD_WINDOW-1 and LOAD_WINDOW+3 cycles after the last strobe ends.
- R4: The page number is address bits 14..6. A load whose page number differs from the first load of the open page is dropped, page_err pulses high for exactly one cycle, and the targeted location keeps its old value.
- R5: busy stays high for PROG_CYCLES cycles (a bench tolerance of +2 applies). After busy falls, every loaded byte reads back from the array. The array is written only while busy=1.
- R6: A read while busy=1 returns the inverse of bit 7 of the last loaded byte on dout[7], and zero on dout[5:0].
- R7: While busy=1, dout[6] takes opposite values on two successive reads. The flip occurs when a read ends. It never changes while busy=0.
- R8: A strobe occurring while busy=1 loads nothing. It neither starts another programming phase nor alters the array.
- R9: dout_en=1 exactly when ce_n=0 and oe_n=0. While dout_en=0, dout is zero, standing in for a released bus.
- R10: After reset, busy=0, page_err=0, dout_en=0 with inputs idle, and the page buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; bits 14..6 select the page |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or polling status; zero when not driven |
| dout_en | output | 1 | High when dout is driven onto the bus |
| busy | output | 1 | Programming phase in progress |
| page_err | output | 1 | One-cycle pulse when a load is dropped for a page mismatch |

## Verification
The assertions check the following on every cycle:
- A load is taken only at the end of a strobe.
- No load is taken while programming.
- The array is written only during programming.
- page_err is a single-cycle pulse.
- The bus is released whenever either read enable is high.
- Status reads carry zero low bits.
- The toggle bit holds still outside programming.

Other behaviours span whole sequences, and only the directed scenarios can show them:
- Address and data capture at the correct enable edges in a chip-enable-controlled write.
- Rejection of short strobes and of writes with output enable low.
- Extension of the load window by successive loads.
- Dropping of a foreign-page load.
- Ignoring of writes during programming.
- Polling values against the last byte loaded.

// File: rtl/nvm_pw_pkg.sv
package nvm_pw_pkg;
   typedef enum logic [1:0] {
      PW_IDLE = 2'd0,
      PW_LOAD = 2'd1,
      PW_PROG = 2'd2
   } pw_state_e;
endpackage

// File: rtl/nvm_pw_strobe.sv
// Write strobe recognition: address at strobe start, data at strobe end,
// with an optional minimum-width noise filter.
module nvm_pw_strobe #(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 8,
   parameter int MIN_PULSE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              block,
   output logic              wr_act,
   output logic              ld_stb,
   output logic [ADDR_W-1:0] ld_addr,
   output logic [DATA_W-1:0] ld_data
);
   logic              wr_q;
   logic              pulse_ok;
   logic [ADDR_W-1:0] a_lat;
   logic [DATA_W-1:0] d_lat;

   assign wr_act = !ce_n && !we_n && oe_n;

   generate
      if (MIN_PULSE > 1) begin : g_filter
         localparam int CNT_W = $clog2(MIN_PULSE + 1);
         logic [CNT_W-1:0] len_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               len_q <= '0;
            else if (wr_act && !wr_q)
               len_q <= CNT_W'(1);
            else if (wr_act && len_q != CNT_W'(MIN_PULSE))
               len_q <= len_q + CNT_W'(1);
         end
         assign pulse_ok = (len_q == CNT_W'(MIN_PULSE));
      end else begin : g_nofilter
         assign pulse_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         a_lat   <= '0;
         d_lat   <= '0;
         ld_stb  <= 1'b0;
         ld_addr <= '0;
         ld_data <= '0;
      end else begin
         wr_q <= wr_act;
         if (wr_act && !wr_q) a_lat <= addr;
         if (wr_act) d_lat <= din;
         ld_stb  <= wr_q && !wr_act && pulse_ok && !block;
         ld_addr <= a_lat;
         ld_data <= d_lat;
      end
   end

   // R1
   load_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb |-> ($past(!wr_act) && $past(wr_act, 2)));
endmodule

// File: rtl/nvm_pw_pagebuf.sv
// Page buffer, load-window timer and self-timed programming sequencer.
module nvm_pw_pagebuf import nvm_pw_pkg::*; #(
   parameter int ADDR_W      = 15,
   parameter int DATA_W      = 8,
   parameter int PAGE_BYTES  = 64,
   parameter int LOAD_WINDOW = 20,
   parameter int PROG_CYCLES = 80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_act,
   input  logic              ld_stb,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   output logic              busy,
   output logic              page_err,
   output logic              last_msb,
   output logic              mw_en,
   output logic [ADDR_W-1:0] mw_addr,
   output logic [DATA_W-1:0] mw_data
);
   localparam int PAGE_AW = $clog2(PAGE_BYTES);
   localparam int TAG_W   = ADDR_W - PAGE_AW;
   localparam int WIN_W   = $clog2(LOAD_WINDOW);
   localparam int PRG_W   = $clog2(PROG_CYCLES + 1);

   pw_state_e             state;
   logic [TAG_W-1:0]      tag;
   logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] slot_vld;
   logic [WIN_W-1:0]      idle_cnt;
   logic [PRG_W-1:0]      prog_cnt;
   logic                  err_q;
   logic                  last_q;

   logic [TAG_W-1:0]   ld_tag;
   logic [PAGE_AW-1:0] ld_idx;
   logic               same_page;
   logic               take;
   logic [PAGE_AW-1:0] drain_idx;
   logic               drain_live;

   assign ld_tag     = ld_addr[ADDR_W-1:PAGE_AW];
   assign ld_idx     = ld_addr[PAGE_AW-1:0];
   assign same_page  = (state == PW_IDLE) || (ld_tag == tag);
   assign take       = ld_stb && (state != PW_PROG) && same_page;
   assign drain_idx  = prog_cnt[PAGE_AW-1:0];
   assign drain_live = (state == PW_PROG) && (prog_cnt < PRG_W'(PAGE_BYTES));

   assign busy     = (state == PW_PROG);
   assign page_err = err_q;
   assign last_msb = last_q;
   assign mw_en    = drain_live && slot_vld[drain_idx];
   assign mw_addr  = {tag, drain_idx};
   assign mw_data  = slot_data[drain_idx];

   always_ff @(posedge clk) begin
      if (take) slot_data[ld_idx] <= ld_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PW_IDLE;
         tag      <= '0;
         slot_vld <= '0;
         idle_cnt <= '0;
         prog_cnt <= '0;
         err_q    <= 1'b0;
         last_q   <= 1'b0;
      end else begin
         err_q <= ld_stb && (state != PW_PROG) && !same_page;
         if (take) begin
            slot_vld[ld_idx] <= 1'b1;
            last_q           <= ld_data[DATA_W-1];
         end
         unique case (state)
            PW_IDLE: begin
               if (take) begin
                  state    <= PW_LOAD;
                  tag      <= ld_tag;
                  idle_cnt <= '0;
               end
            end
            PW_LOAD: begin
               if (wr_act || ld_stb) begin
                  idle_cnt <= '0;
               end else if (idle_cnt == WIN_W'(LOAD_WINDOW - 1)) begin
                  state    <= PW_PROG;
                  prog_cnt <= '0;
               end else begin
                  idle_cnt <= idle_cnt + WIN_W'(1);
               end
            end
            PW_PROG: begin
               if (prog_cnt == PRG_W'(PROG_CYCLES - 1)) begin
                  state    <= PW_IDLE;
                  slot_vld <= '0;
               end else begin
                  prog_cnt <= prog_cnt + PRG_W'(1);
               end
            end
            default: state <= PW_IDLE;
         endcase
      end
   end

   // R8
   no_load_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ld_stb);
   // R4
   err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_err |=> !page_err);
   // R5
   array_write_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mw_en |-> busy);
   // R5
   prog_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_cnt < PRG_W'(PROG_CYCLES));
endmodule

// File: rtl/nvm_pw_readpath.sv
// Read mux: array data when idle, polling status while programming.
module nvm_pw_readpath #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              busy,
   input  logic              last_msb,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   logic              rd;
   logic              rd_q;
   logic              tog;
   logic [DATA_W-1:0] status;

   assign rd      = !ce_n && !oe_n;
   assign dout_en = rd;

   always_comb begin
      status             = '0;
      status[DATA_W-1]   = !last_msb;
      status[DATA_W-2]   = tog;
      dout               = '0;
      if (rd) dout = busy ? status : arr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         tog  <= 1'b0;
      end else begin
         rd_q <= rd;
         if (busy && rd_q && !rd) tog <= !tog;
      end
   end

   // R9
   bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |-> (!dout_en && dout == '0));
   // R6
   status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dout_en) |-> (dout[DATA_W-3:0] == '0));
   // R7
   toggle_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(tog));
endmodule

// File: rtl/nvm_page_writer.sv
module nvm_page_writer #(
   parameter int ADDR_W      = 15,
   parameter int DATA_W      = 8,
   parameter int PAGE_BYTES  = 64,
   parameter int MEM_AW      = 10,
   parameter int LOAD_WINDOW = 20,
   parameter int PROG_CYCLES = 80,
   parameter int MIN_PULSE   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              busy,
   output logic              page_err
);
   localparam int PAGE_AW   = $clog2(PAGE_BYTES);
   localparam int MEM_DEPTH = 1 << MEM_AW;

   generate
      if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 2");
      end
      if (MEM_AW <= PAGE_AW || MEM_AW > ADDR_W) begin : g_bad_mem
         $error("MEM_AW must exceed the page offset width and fit in ADDR_W");
      end
      if (PROG_CYCLES < PAGE_BYTES) begin : g_bad_prog
         $error("PROG_CYCLES must cover one drain cycle per page slot");
      end
      if (LOAD_WINDOW < 2 || DATA_W < 3) begin : g_bad_misc
         $error("LOAD_WINDOW must be >= 2 and DATA_W >= 3");
      end
   endgenerate

   logic              wr_act;
   logic              ld_stb;
   logic [ADDR_W-1:0] ld_addr;
   logic [DATA_W-1:0] ld_data;
   logic              last_msb;
   logic              mw_en;
   logic [ADDR_W-1:0] mw_addr;
   logic [DATA_W-1:0] mw_data;
   logic [MEM_AW-1:0] rd_idx;
   logic [MEM_AW-1:0] wr_idx;
   logic [DATA_W-1:0] arr_data;
   logic [DATA_W-1:0] mem [MEM_DEPTH];

   generate
      if (MEM_AW < ADDR_W) begin : g_alias
         logic unused_hi;
         assign unused_hi = ^{addr[ADDR_W-1:MEM_AW], mw_addr[ADDR_W-1:MEM_AW]};
         assign rd_idx    = addr[MEM_AW-1:0];
         assign wr_idx    = mw_addr[MEM_AW-1:0];
      end else begin : g_full
         assign rd_idx = addr;
         assign wr_idx = mw_addr;
      end
   endgenerate

   nvm_pw_strobe #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
   ) u_strobe (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .block(busy), .wr_act(wr_act),
      .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_data(ld_data)
   );

   nvm_pw_pagebuf #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
      .LOAD_WINDOW(LOAD_WINDOW), .PROG_CYCLES(PROG_CYCLES)
   ) u_pagebuf (
      .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .ld_stb(ld_stb),
      .ld_addr(ld_addr), .ld_data(ld_data), .busy(busy), .page_err(page_err),
      .last_msb(last_msb), .mw_en(mw_en), .mw_addr(mw_addr), .mw_data(mw_data)
   );

   always_ff @(posedge clk) begin
      if (mw_en) mem[wr_idx] <= mw_data;
   end
   assign arr_data = mem[rd_idx];

   nvm_pw_readpath #(
      .DATA_W(DATA_W)
   ) u_readpath (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
      .last_msb(last_msb), .arr_data(arr_data), .dout(dout), .dout_en(dout_en)
   );
endmodule

// File: tb/nvm_page_writer_tb.sv
module nvm_page_writer_tb;
   localparam int W  = 20;
   localparam int PC = 80;
   localparam int MP = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ce_n, oe_n, we_n;
   logic [14:0] addr;
   logic [7:0]  din;
   logic [7:0]  dout;
   logic        dout_en, busy, page_err;

   int n_chk  = 0;
   int n_fail = 0;
   int busy_cyc = 0;
   int err_cnt  = 0;

   always #10 clk = ~clk;

   nvm_page_writer #(.LOAD_WINDOW(W), .PROG_CYCLES(PC), .MIN_PULSE(MP)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
      .busy(busy), .page_err(page_err)
   );

   always @(posedge clk) begin
      if (busy) busy_cyc <= busy_cyc + 1;
      if (page_err) err_cnt <= err_cnt + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_range(input string req, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wr(input logic [14:0] a, input logic [7:0] d, input int low);
      @(negedge clk); addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b1;
      @(negedge clk); we_n = 1'b0;
      repeat (low) @(negedge clk);
      we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1;
   endtask

   task automatic rd(input logic [14:0] a, output logic [7:0] v);
      @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      #5 v = dout;
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
   endtask

   // waits for busy, returns latency and length of the programming phase
   task automatic wait_prog(output int lat, output int len);
      lat = 0; len = 0;
      while (!busy && lat < 400) begin @(negedge clk); lat++; end
      while (busy && len < 400) begin @(negedge clk); len++; end
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 busy after reset", busy, 0);
      check("R10 page_err after reset", page_err, 0);
      check("R10 dout_en after reset", dout_en, 0);
      repeat (W + 5) @(negedge clk);
      check("R10 empty buffer never programs", busy_cyc, 0);
   endtask

   task automatic t_bus();
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; #5;
      check("R9 ce_n high releases bus", {dout_en, dout}, 0);
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #5;
      check("R9 oe_n high releases bus", {dout_en, dout}, 0);
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; #5;
      check("R9 both low drives bus", dout_en, 1);
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic t_page_basic();
      int lat, len;
      logic [7:0] v;
      wr(15'h140, 8'h10, MP + 1);
      wr(15'h141, 8'h99, MP + 1);
      wait_prog(lat, len);
      check_range("R3 busy latency after last load", lat, W - 1, W + 3);
      check_range("R5 programming length", len, PC, PC + 2);
      rd(15'h140, v); check("R5 readback 0x140", v, 8'h10);
      rd(15'h141, v); check("R5 readback 0x141", v, 8'h99);
   endtask

   task automatic t_poll(input logic [14:0] a, input logic [7:0] d);
      logic [7:0] v1, v2, v;
      int lat, len;
      wr(a, d, MP + 1);
      lat = 0;
      while (!busy && lat < 400) begin @(negedge clk); lat++; end
      rd(a, v1);
      rd(a, v2);
      check("R6 status bit7 inverts last data", v1[7], !d[7]);
      check("R6 status low bits zero", v1[5:0], 0);
      check("R7 toggle bit flips between reads", v1[6] ^ v2[6], 1);
      wait_prog(lat, len);
      rd(a, v); check("R6 true data after programming", v, d);
   endtask

   task automatic t_busy_ignore();
      int lat, len, b0;
      logic [7:0] v;
      wr(15'h140, 8'h33, MP + 1);
      lat = 0;
      while (!busy && lat < 400) begin @(negedge clk); lat++; end
      wr(15'h141, 8'h44, MP + 1);
      wait_prog(lat, len);
      b0 = busy_cyc;
      repeat (W + 8) @(negedge clk);
      check("R8 no new programming after busy write", busy_cyc, b0);
      rd(15'h140, v); check("R8 pre-busy byte written", v, 8'h33);
      rd(15'h141, v); check("R8 busy write ignored", v, 8'h99);
   endtask

   task automatic t_mismatch();
      int lat, len, e0;
      logic [7:0] v;
      wr(15'h105, 8'h77, MP + 1);
      wait_prog(lat, len);
      e0 = err_cnt;
      wr(15'h0C5, 8'h11, MP + 1);
      wr(15'h105, 8'h22, MP + 1);
      wait_prog(lat, len);
      check("R4 one page_err pulse", err_cnt - e0, 1);
      rd(15'h0C5, v); check("R4 matching load kept", v, 8'h11);
      rd(15'h105, v); check("R4 foreign page untouched", v, 8'h77);
   endtask

   task automatic t_ce_ctrl();
      int lat, len;
      logic [7:0] v;
      wr(15'h200, 8'h01, MP + 1);
      wr(15'h201, 8'h02, MP + 1);
      wait_prog(lat, len);
      // we_n falls first, ce_n falls last; ce_n rises first, we_n last
      @(negedge clk); oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b1; addr = 15'h200; din = 8'h5A;
      @(negedge clk); addr = 15'h201; ce_n = 1'b0;
      repeat (MP + 1) @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk); din = 8'hFF;
      @(negedge clk); we_n = 1'b1; addr = 15'h200;
      wait_prog(lat, len);
      rd(15'h200, v); check("R1 address from later falling edge", v, 8'h01);
      rd(15'h201, v); check("R1 data from earlier rising edge", v, 8'h5A);
   endtask

   task automatic t_blocked();
      int b0;
      logic [7:0] v;
      b0 = busy_cyc;
      @(negedge clk); addr = 15'h201; din = 8'hC0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
      repeat (MP + 2) @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
      repeat (W + 8) @(negedge clk);
      check("R1 oe_n low blocks write", busy_cyc, b0);
      rd(15'h201, v); check("R1 blocked write left data", v, 8'h5A);
   endtask

   task automatic t_glitch();
      int b0, lat, len;
      logic [7:0] v;
      b0 = busy_cyc;
      wr(15'h201, 8'hEE, MP - 1);
      repeat (W + 8) @(negedge clk);
      check("R2 short strobe starts nothing", busy_cyc, b0);
      rd(15'h201, v); check("R2 short strobe left data", v, 8'h5A);
      wr(15'h201, 8'hEE, MP);
      wait_prog(lat, len);
      rd(15'h201, v); check("R2 minimum strobe accepted", v, 8'hEE);
   endtask

   task automatic t_chain();
      int lat, len;
      logic [7:0] v;
      for (int i = 0; i < 4; i++) begin
         wr(15'h0C0 + 15'(i), 8'hA0 + 8'(i), MP + 1);
         if (i < 3) begin
            repeat (W - 8) @(negedge clk);
            check("R3 window extended by next load", busy, 0);
         end
      end
      wait_prog(lat, len);
      check_range("R3 latency after chained loads", lat, W - 1, W + 3);
      for (int i = 0; i < 4; i++) begin
         rd(15'h0C0 + 15'(i), v);
         check("R3 chained page byte", v, 8'hA0 + i);
      end
   endtask

   initial begin
      t_reset();
      t_bus();
      t_page_basic();
      t_poll(15'h3A0, 8'h5C);
      t_poll(15'h3A1, 8'hC3);
      t_busy_ignore();
      t_mismatch();
      t_ce_ctrl();
      t_blocked();
      t_glitch();
      t_chain();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule